// File: doc/BRIEF.md
# Indirect L1 Test Access Sequencer

This block gives software an indirect path into L1 data memory. Software writes a 32-bit test command word through a small register port. The block decodes that word into a physical L1 address: selected command bits are scattered into fixed address positions, and the result is ORed with an SRAM base supplied on an input. The block then moves one 64-bit doubleword over a request/acknowledge memory port. The direction is set by the command. A write stores the two 32-bit test data registers to memory. A read loads the two registers from memory.

Two kinds of command are refused with an error flag: commands that set a reserved bit, and commands that ask for tag-array access. A command word of zero is stored and starts nothing. While an access is in flight the block is busy, and every register write is dropped.

Top module: `l1_test_access`

## Requirements
- R1: While an access is outstanding, `mem_addr_o` equals `sram_base_i` (sampled at command acceptance) ORed with: command bit 26 placed at address bit 11, bit 24 at bit 21, bit 23 at bit 15, and bits 17:16 at bits 13:12.
- R2: Command bits 14 and 10:3 (mask 0x0000_47F8) appear unchanged at the same address bit positions.
- R3: A zero command written while idle is stored and reads back as zero. It starts no memory request and leaves `err_o` unchanged.
- R4: A non-zero command written while idle with any bit of mask 0xFA7C_B801 set raises `err_o` and starts no request. A later accepted non-zero command that is good clears `err_o`.
- R5: A non-zero command with bit 2 (data-array select) clear is a tag-array request. It raises `err_o` and starts no request.
- R6: Command bit 1 set selects a store. `mem_we_o` is 1 and `mem_wdata_o` is {data register 1, data register 0}, so data register 0 sits in the low 32 bits.
- R7: Command bit 1 clear selects a load. On acknowledge, data register 0 takes `mem_rdata_i[31:0]` and data register 1 takes `mem_rdata_i[63:32]`.
- R8: `busy_o` and `mem_req_o` rise on the clock that accepts a good command. They stay high with the address and direction stable until the cycle in which `mem_ack_i` is sampled high, and are low on the next cycle.
- R9: A command write while busy is ignored. This holds in the acknowledge cycle too: the stored command is unchanged and no second access starts.
- R10: After reset the command and both data registers read zero, and `busy_o`, `err_o` and `mem_req_o` are low.
- R11: `reg_rdata_o` shows, without delay, the register chosen by `reg_sel_i`: 0 command, 1 data 0, 2 data 1, 3 reads zero.
- R12: A data register write while busy is ignored. When it falls in the acknowledge cycle of a load, the loaded value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 command, 1 data 0, 2 data 1 |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Read data of the selected register |
| sram_base_i | input | ADDR_W | SRAM base ORed into the target address |
| busy_o | output | 1 | Access in flight |
| err_o | output | 1 | Last non-zero accepted command was refused |
| mem_req_o | output | 1 | Memory request, held until acknowledge |
| mem_we_o | output | 1 | 1 store, 0 load |
| mem_addr_o | output | ADDR_W | Doubleword target address |
| mem_wdata_o | output | 2*DATA_W | Store data {data 1, data 0} |
| mem_ack_i | input | 1 | Memory acknowledge, one cycle |
| mem_rdata_i | input | 2*DATA_W | Load data, valid with acknowledge |

## Verification
A memory acknowledge can arrive in the same cycle as a register write. Two cases follow from this. A command write that lands on the acknowledge must be dropped. A data-register write that lands on a load acknowledge must lose to the loaded doubleword. The bench provokes both cases by watching its memory responder and driving the write in exactly the cycle the acknowledge is raised. A behavioural model clocked alongside the design judges the outcome. Directed read-backs then confirm that the command register is unchanged and that the data register holds the memory value.

// File: rtl/l1t_pkg.sv
package l1t_pkg;
  localparam int unsigned CMD_W = 32;
  localparam logic [CMD_W-1:0] CMD_RSVD_MASK = 32'hFA7C_B801;
  localparam logic [CMD_W-1:0] CMD_PASS_MASK = 32'h0000_47F8;
  localparam int unsigned BIT_WR   = 1;
  localparam int unsigned BIT_DARR = 2;
  localparam int unsigned BIT_SUB  = 16;
  localparam int unsigned BIT_BANK = 23;
  localparam int unsigned BIT_DSEL = 24;
  localparam int unsigned BIT_WAY  = 26;
  localparam int unsigned A_WAY  = 11;
  localparam int unsigned A_SUB  = 12;
  localparam int unsigned A_BANK = 15;
  localparam int unsigned A_DSEL = 21;

  typedef enum logic [1:0] {
    SEL_CMD  = 2'd0,
    SEL_D0   = 2'd1,
    SEL_D1   = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/l1t_addr_map.sv
module l1t_addr_map #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic              way_i,
  input  logic              dsel_i,
  input  logic              bank_i,
  input  logic [1:0]        sub_i,
  input  logic [ADDR_W-1:0] pass_i,
  output logic [ADDR_W-1:0] addr_o
);
  import l1t_pkg::*;

  logic [ADDR_W-1:0] scat;

  always_comb begin
    scat = '0;
    scat[A_WAY]          = way_i;
    scat[A_DSEL]         = dsel_i;
    scat[A_BANK]         = bank_i;
    scat[A_SUB+1:A_SUB]  = sub_i;
    addr_o = base_i | scat | pass_i;
  end
endmodule

// File: rtl/l1t_cmd_check.sv
module l1t_cmd_check (
  input  logic [l1t_pkg::CMD_W-1:0] cmd_i,
  output logic                      zero_o,
  output logic                      rsvd_o,
  output logic                      tag_o,
  output logic                      bad_o
);
  import l1t_pkg::*;

  always_comb begin
    zero_o = (cmd_i == '0);
    rsvd_o = |(cmd_i & CMD_RSVD_MASK);
    tag_o  = ~cmd_i[BIT_DARR];
    bad_o  = ~zero_o & (rsvd_o | tag_o);
  end
endmodule

// File: rtl/l1t_data_regs.sv
module l1t_data_regs #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_WORD = 2
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [N_WORD-1:0]              wr_en_i,
  input  logic [DATA_W-1:0]              wdata_i,
  input  logic                           load_i,
  input  logic [N_WORD*DATA_W-1:0]       load_data_i,
  output logic [N_WORD-1:0][DATA_W-1:0]  words_o
);
  for (genvar i = 0; i < N_WORD; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         words_o[i] <= '0;
      else if (load_i)     words_o[i] <= load_data_i[i*DATA_W +: DATA_W];
      else if (wr_en_i[i]) words_o[i] <= wdata_i;
    end
  end

  // R12: the top must never request a register write in a load cycle
  p_no_wr_on_load_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> (wr_en_i == '0));
endmodule

// File: rtl/l1_test_access.sv
module l1_test_access #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_wr_i,
  input  logic [1:0]          reg_sel_i,
  input  logic [DATA_W-1:0]   reg_wdata_i,
  output logic [DATA_W-1:0]   reg_rdata_o,
  input  logic [ADDR_W-1:0]   sram_base_i,
  output logic                busy_o,
  output logic                err_o,
  output logic                mem_req_o,
  output logic                mem_we_o,
  output logic [ADDR_W-1:0]   mem_addr_o,
  output logic [2*DATA_W-1:0] mem_wdata_o,
  input  logic                mem_ack_i,
  input  logic [2*DATA_W-1:0] mem_rdata_i
);
  import l1t_pkg::*;

  localparam int unsigned N_WORD = 2;
  localparam int unsigned MEM_W  = N_WORD * DATA_W;

  logic              busy_q, err_q, we_q;
  logic [DATA_W-1:0] cmd_q;
  logic [ADDR_W-1:0] addr_q, map_addr;
  logic              acc_ok, cmd_wr, start, done, load;
  logic              c_zero, c_rsvd, c_tag, c_bad;
  logic [N_WORD-1:0] dwr_en;
  logic [N_WORD-1:0][DATA_W-1:0] words;
  reg_sel_e          sel;

  assign sel    = reg_sel_e'(reg_sel_i);
  assign acc_ok = reg_wr_i & ~busy_q;
  assign cmd_wr = acc_ok & (sel == SEL_CMD);
  assign start  = cmd_wr & ~c_zero & ~c_bad;
  assign done   = busy_q & mem_ack_i;
  assign load   = done & ~we_q;
  assign dwr_en = {acc_ok & (sel == SEL_D1), acc_ok & (sel == SEL_D0)};

  l1t_cmd_check u_chk (
    .cmd_i  (CMD_W'(reg_wdata_i)),
    .zero_o (c_zero),
    .rsvd_o (c_rsvd),
    .tag_o  (c_tag),
    .bad_o  (c_bad)
  );

  l1t_addr_map #(.ADDR_W(ADDR_W)) u_map (
    .base_i (sram_base_i),
    .way_i  (reg_wdata_i[BIT_WAY]),
    .dsel_i (reg_wdata_i[BIT_DSEL]),
    .bank_i (reg_wdata_i[BIT_BANK]),
    .sub_i  (reg_wdata_i[BIT_SUB+1:BIT_SUB]),
    .pass_i (ADDR_W'(reg_wdata_i & DATA_W'(CMD_PASS_MASK))),
    .addr_o (map_addr)
  );

  l1t_data_regs #(.DATA_W(DATA_W), .N_WORD(N_WORD)) u_data (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (dwr_en),
    .wdata_i     (reg_wdata_i),
    .load_i      (load),
    .load_data_i (mem_rdata_i),
    .words_o     (words)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      we_q   <= 1'b0;
      cmd_q  <= '0;
      addr_q <= '0;
    end else begin
      if (cmd_wr) cmd_q <= reg_wdata_i;
      if (cmd_wr && !c_zero) err_q <= c_bad;
      if (start) begin
        busy_q <= 1'b1;
        addr_q <= map_addr;
        we_q   <= reg_wdata_i[BIT_WR];
      end else if (done) begin
        busy_q <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (sel)
      SEL_CMD: reg_rdata_o = cmd_q;
      SEL_D0:  reg_rdata_o = words[0];
      SEL_D1:  reg_rdata_o = words[1];
      default: reg_rdata_o = '0;
    endcase
  end

  assign busy_o      = busy_q;
  assign err_o       = err_q;
  assign mem_req_o   = busy_q;
  assign mem_we_o    = we_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = MEM_W'(words);

  p_req_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  p_ack_release_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_ack_i) |=> !busy_o);
  p_busy_cmd_ign_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && reg_wr_i) |=> $stable(cmd_q));
  p_reject_no_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && reg_wr_i && sel == SEL_CMD && |(reg_wdata_i & DATA_W'(CMD_RSVD_MASK)))
      |=> (!mem_req_o && err_o));
  p_tag_no_req_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && reg_wr_i && sel == SEL_CMD && reg_wdata_i != '0 && !reg_wdata_i[BIT_DARR])
      |=> (!mem_req_o && err_o));
  p_zero_no_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && reg_wr_i && sel == SEL_CMD && reg_wdata_i == '0)
      |=> (!mem_req_o && $stable(err_o)));
endmodule

// File: tb/l1_test_access_tb.sv
module l1_test_access_tb;
  localparam logic [31:0] RSVD = 32'hFA7C_B801;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [1:0]  reg_sel_i = 2'd3;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [31:0] sram_base_i = 32'hFF80_0000;
  logic        busy_o, err_o, mem_req_o, mem_we_o;
  logic [31:0] mem_addr_o;
  logic [63:0] mem_wdata_o;
  logic        mem_ack_i = 1'b0;
  logic [63:0] mem_rdata_i = '0;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  int ack_delay = 0;
  int rcnt = 0;
  int n_acks = 0;
  logic [63:0] mem [logic [31:0]];

  // reference model state
  logic        m_busy = 0, m_err = 0, m_we = 0;
  logic [31:0] m_cmd = 0, m_d0 = 0, m_d1 = 0, m_addr = 0;

  always #5 clk = ~clk;

  l1_test_access u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(reg_wr_i), .reg_sel_i(reg_sel_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .sram_base_i(sram_base_i),
    .busy_o(busy_o), .err_o(err_o), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
    .mem_rdata_i(mem_rdata_i)
  );

  function automatic logic [31:0] exp_addr(logic [31:0] base, logic [31:0] c);
    logic [31:0] a = base;
    a[11] = a[11] | c[26];
    a[21] = a[21] | c[24];
    a[15] = a[15] | c[23];
    a[13] = a[13] | c[17];
    a[12] = a[12] | c[16];
    a[14] = a[14] | c[14];
    for (int i = 3; i <= 10; i++) a[i] = a[i] | c[i];
    return a;
  endfunction

  function automatic logic [63:0] fill(logic [31:0] a);
    return {~a, a ^ 32'h5A5A_0000};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference
  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_err = 0; m_we = 0; m_cmd = 0; m_d0 = 0; m_d1 = 0; m_addr = 0;
    end else if (m_busy) begin
      if (mem_ack_i) begin
        m_busy = 0;
        if (!m_we) begin m_d0 = mem_rdata_i[31:0]; m_d1 = mem_rdata_i[63:32]; end
      end
    end else if (reg_wr_i) begin
      if (reg_sel_i == 2'd0) begin
        m_cmd = reg_wdata_i;
        if (reg_wdata_i != 0) begin
          if ((reg_wdata_i & RSVD) != 0 || !reg_wdata_i[2]) m_err = 1;
          else begin
            m_err = 0; m_busy = 1; m_we = reg_wdata_i[1];
            m_addr = exp_addr(sram_base_i, reg_wdata_i);
          end
        end
      end else if (reg_sel_i == 2'd1) m_d0 = reg_wdata_i;
      else if (reg_sel_i == 2'd2) m_d1 = reg_wdata_i;
    end
  end

  // per-clock comparison, before the next negedge
  always @(posedge clk) begin
    #3;
    if (rst_ni) begin
      logic [31:0] er;
      er = (reg_sel_i == 0) ? m_cmd : (reg_sel_i == 1) ? m_d0 : (reg_sel_i == 2) ? m_d1 : 32'h0;
      chk(busy_o == m_busy, "R8 busy", 64'(busy_o), 64'(m_busy));
      chk(mem_req_o == m_busy, "R8 req", 64'(mem_req_o), 64'(m_busy));
      chk(err_o == m_err, "R4 err", 64'(err_o), 64'(m_err));
      chk(reg_rdata_o == er, "R11 rdata", 64'(reg_rdata_o), 64'(er));
      if (m_busy) begin
        chk(mem_addr_o == m_addr, "R1 addr", 64'(mem_addr_o), 64'(m_addr));
        chk(mem_we_o == m_we, "R6 we", 64'(mem_we_o), 64'(m_we));
        if (m_we) chk(mem_wdata_o == {m_d1, m_d0}, "R6 wdata", mem_wdata_o, {m_d1, m_d0});
      end
    end
  end

  // memory responder
  always @(negedge clk) begin
    if (mem_ack_i) begin
      mem_ack_i = 0;
    end else if (mem_req_o) begin
      if (rcnt >= ack_delay) begin
        rcnt = 0; n_acks++;
        if (mem_we_o) mem[mem_addr_o] = mem_wdata_o;
        else mem_rdata_i = mem.exists(mem_addr_o) ? mem[mem_addr_o] : fill(mem_addr_o);
        mem_ack_i = 1;
      end else rcnt++;
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog act=%0d exp=<100000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] s, input logic [31:0] v);
    @(negedge clk); reg_wr_i = 1; reg_sel_i = s; reg_wdata_i = v;
    @(negedge clk); reg_wr_i = 0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk); reg_sel_i = s;
    @(posedge clk); #3; v = reg_rdata_o;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (mem_req_o) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic collide(input logic [1:0] s, input logic [31:0] v);
    @(negedge clk); #1;
    while (!mem_ack_i) begin @(negedge clk); #1; end
    reg_wr_i = 1; reg_sel_i = s; reg_wdata_i = v;
    @(negedge clk); reg_wr_i = 0;
  endtask

  initial begin
    logic [31:0] v, c, a;
    int acks0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy_o && !err_o && !mem_req_o, "R10 flags", {busy_o, err_o, mem_req_o}, 0);
    rst_ni = 1;
    for (int s = 0; s < 4; s++) begin
      rd(s[1:0], v);
      chk(v == 0, "R10 reg", v, 0);
    end

    // R6 store with scattered fields
    wr(1, 32'h1122_3344); wr(2, 32'hAABB_CCDD);
    c = 32'h0403_0000 | 32'h0000_0006 | 32'h0000_0008;
    a = exp_addr(sram_base_i, c);
    ack_delay = 2; wr(0, c); wait_idle();
    chk(mem.exists(a) && mem[a] == 64'hAABB_CCDD_1122_3344, "R6 stored", mem.exists(a) ? mem[a] : 0, 64'hAABB_CCDD_1122_3344);

    // R2 and R7 load with pass-through bits
    sram_base_i = 32'hFF90_0000;
    c = 32'h0181_47FC & ~32'h2;
    a = exp_addr(sram_base_i, c);
    chk(a[14] && a[10:3] == 8'hFF, "R2 pass", a, a);
    ack_delay = 0; wr(0, c); wait_idle();
    rd(1, v); chk(v == fill(a)[31:0], "R7 d0 low", v, fill(a)[31:0]);
    rd(2, v); chk(v == fill(a)[63:32], "R7 d1 high", v, fill(a)[63:32]);

    // R7 round trip from the stored doubleword
    sram_base_i = 32'hFF80_0000;
    c = 32'h0403_000C;
    ack_delay = 4; wr(0, c); wait_idle();
    rd(1, v); chk(v == 32'h1122_3344, "R7 rt d0", v, 32'h1122_3344);
    rd(2, v); chk(v == 32'hAABB_CCDD, "R7 rt d1", v, 32'hAABB_CCDD);

    // R5 tag-array request
    acks0 = n_acks;
    wr(0, 32'h0000_0002); repeat (3) @(negedge clk);
    chk(err_o && n_acks == acks0, "R5 tag err", {err_o, 32'(n_acks - acks0)}, 64'h1_0000_0000);

    // R3 zero command keeps err, no access
    wr(0, 32'h0); repeat (3) @(negedge clk);
    rd(0, v);
    chk(v == 0 && err_o && n_acks == acks0, "R3 zero", {err_o, v}, 64'h1_0000_0000);

    // R4 every reserved bit, with data-array select set
    for (int b = 0; b < 32; b++) begin
      if (RSVD[b]) begin
        wr(0, 32'h4 | (32'h1 << b)); @(negedge clk);
        chk(err_o && !mem_req_o && n_acks == acks0, "R4 rsvd", {err_o, mem_req_o}, 64'h2);
      end
    end
    // R4 good command clears err
    ack_delay = 1; wr(0, 32'h0000_0004); wait_idle();
    chk(!err_o, "R4 clear", 64'(err_o), 0);

    // R9 and R12 writes while busy ignored
    ack_delay = 6; acks0 = n_acks;
    c = 32'h0001_0104; wr(0, c);
    wr(0, 32'h0000_0006); wr(1, 32'hDEAD_BEEF);
    wait_idle();
    a = exp_addr(sram_base_i, c);
    rd(0, v); chk(v == c, "R9 cmd kept", v, c);
    chk(n_acks == acks0 + 1, "R9 one access", n_acks - acks0, 1);
    rd(1, v); chk(v == fill(a)[31:0], "R12 d0 load", v, fill(a)[31:0]);

    // R9 command write in the acknowledge cycle
    ack_delay = 3; acks0 = n_acks;
    c = 32'h0080_0204; wr(0, c);
    collide(0, 32'h0000_000E);
    repeat (3) @(negedge clk);
    rd(0, v); chk(v == c, "R9 ack-cycle cmd", v, c);
    chk(n_acks == acks0 + 1 && !busy_o, "R9 ack-cycle no start", n_acks - acks0, 1);

    // R12 data write in the acknowledge cycle of a load
    ack_delay = 2;
    c = 32'h0400_0404; a = exp_addr(sram_base_i, c); wr(0, c);
    collide(1, 32'h0BAD_F00D);
    repeat (2) @(negedge clk);
    rd(1, v); chk(v == fill(a)[31:0], "R12 ack-cycle d0", v, fill(a)[31:0]);

    // R8 back-to-back acceptance right after acknowledge
    ack_delay = 0; acks0 = n_acks;
    wr(0, 32'h0000_0014);
    wr(0, 32'h0000_0024);
    wait_idle();
    chk(n_acks == acks0 + 2, "R8 back-to-back", n_acks - acks0, 2);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule